// File: doc/BRIEF.md
# Invalid Block Map Builder

This sequencer runs on the controller side of a raw NAND array after power-up. It builds a map of the blocks the factory marked invalid. For each block, in ascending block order, it asks an abstract page-read port for the first spare-area byte of the block's first page. When that byte is blank (FFh), it also asks for the same byte of the block's second page. A block is marked invalid when either marker byte is not FFh, or when the read port reports an error.

Each invalid block sets its bit in a one-bit-per-block map RAM. Software reads that map through a lookup port with a one-clock latency. The block also keeps a running count of invalid blocks. A flag goes high as soon as the count exceeds the number of invalid blocks the array is allowed to have, which is 40 out of 2048 by default.

A start pulse begins a scan from any state. The scan first sweeps the whole map to zero, then walks the blocks and finally holds a done indication.

Top module: `bad_block_scanner`

## Requirements
- R1: A start pulse sampled at a clock edge begins a new scan: from the next cycle `scan_busy` is 1, `scan_done` is 0, and `bad_count` and `too_many_bad` are 0. This applies from idle and from a finished scan.
- R2: Each scan first clears every map bit. `rd_req` stays low for the first NUM_BLOCKS cycles after the start edge and rises in the cycle after that. A block marked invalid in an earlier scan reads 0 after a scan that finds it valid.
- R3: Blocks are read in ascending order from block 0. Each request carries row = block × PAGES_PER_BLOCK + page and column = PAGE_DATA_BYTES, the first spare byte. `rd_req` and `rd_row` hold steady until `rd_done` is seen with `rd_req` high.
- R4: The page-1 request (row = block × PAGES_PER_BLOCK + 1) is made only when page 0 returned FFh without error. Otherwise the next request is page 0 of the next block.
- R5: A block is invalid when a returned marker byte differs from FFh, or when `rd_err` is high with `rd_done`, on either page read.
- R6: After a scan, `lkp_bad` gives 1 for an invalid block and 0 for a valid one, one clock after `lkp_blk` is applied.
- R7: `bad_count` rises by exactly one in the cycle after the accepted `rd_done` that marks a block invalid. It does not change otherwise within a scan.
- R8: `too_many_bad` is 1 exactly while `bad_count` exceeds MAX_BAD (default 40). A count equal to MAX_BAD leaves it low.
- R9: `scan_done` rises two clocks after the final accepted `rd_done` of the last block. It stays high with `rd_req` low and `scan_busy` low until the next start.
- R10: After reset, `rd_req`, `scan_busy`, `scan_done`, `too_many_bad` and `bad_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins or restarts a scan |
| rd_req | output | 1 | Page-read request, held until acknowledged |
| rd_row | output | $clog2(NUM_BLOCKS)+$clog2(PAGES_PER_BLOCK) | Row address: block × pages-per-block + page |
| rd_col | output | $clog2(PAGE_DATA_BYTES+SPARE_BYTES) | Column of the marker byte |
| rd_done | input | 1 | Read completion, with `rd_byte` and `rd_err` valid |
| rd_byte | input | 8 | Byte read at `rd_col` |
| rd_err | input | 1 | Read failed; the block is treated as invalid |
| lkp_blk | input | $clog2(NUM_BLOCKS) | Block number to look up |
| lkp_bad | output | 1 | Map bit of `lkp_blk`, one clock later |
| scan_busy | output | 1 | Clearing or walking blocks |
| scan_done | output | 1 | Scan finished |
| bad_count | output | $clog2(NUM_BLOCKS)+1 | Invalid blocks found so far |
| too_many_bad | output | 1 | Count exceeds MAX_BAD |

## Verification
Each result is due at a known cycle:
- The first request is due NUM_BLOCKS cycles after the start edge.
- A count step is due one cycle after the `rd_done` that marks a block.
- The done flag is due two cycles after the last acknowledge.
- A lookup bit is due one cycle after the block number is applied.

The reference model counts edges from the start pulse. It updates its expected count and map only at the falling edge that follows each acknowledge edge, and compares every output on every falling edge. A value that arrives a cycle early or late is therefore reported at that cycle.

// File: rtl/bbs_pkg.sv
// Shared types for the invalid block map builder.
// Assumes: one marker byte per page read; FFh means "blank".
package bbs_pkg;

    // Scan sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_PAGE0,
        ST_PAGE1,
        ST_ADVANCE,
        ST_DONE
    } scan_state_t;

    // A read marks its block invalid on a failed read or a non-blank marker.
    function automatic logic marker_is_bad(input logic [7:0] mark, input logic failed);
        return failed || (mark != 8'hFF);
    endfunction

endpackage

// File: rtl/bbs_bitmap.sv
// One-bit-per-block map RAM.
// Single write port, single read port with a registered output.
// Assumes: a read and a write to the same address in one cycle return the old bit.
// The contents are not reset; the sequencer sweeps them to zero at every scan start.
module bbs_bitmap #(
    parameter int DEPTH  = 2048,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wbit,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rbit
);

    logic store_q [DEPTH];

    // Write port: one bit per cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wbit;
        end
    end

    // Registered read port, forced to 0 while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbit <= 1'b0;
        end else begin
            rbit <= store_q[raddr];
        end
    end

endmodule

// File: rtl/bbs_tally.sv
// Invalid-block counter with a limit comparator.
// Assumes: a clear and a bump never need to act together (clear wins).
// Assumes: MAX_BAD is below the largest value the counter can hold.
module bbs_tally #(
    parameter int CNT_W   = 12,
    parameter int MAX_BAD = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bump,
    output logic [CNT_W-1:0] count,
    output logic             over_limit
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_BAD);

    // Count the invalid blocks found in the current scan.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (bump) begin
            count <= count + 1'b1;
        end
    end

    // The flag follows the registered count directly.
    always_comb over_limit = (count > LIMIT);

endmodule

// File: rtl/bbs_seq.sv
// Scan sequencer.
// Phases: sweep the map to zero, then issue the marker reads for each block
// in ascending order, then write map bits and bump the counter for invalid blocks.
// Assumes: rd_done is sampled only while rd_req is high.
// Assumes: rd_byte and rd_err are valid in the rd_done cycle.
// A start pulse restarts from any state.
module bbs_seq
    import bbs_pkg::*;
#(
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int PAGE_DATA_BYTES = 2048,
    parameter int SPARE_BYTES     = 64,
    localparam int BLK_W = $clog2(NUM_BLOCKS),
    localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
    localparam int ROW_W = BLK_W + PG_W,
    localparam int COL_W = $clog2(PAGE_DATA_BYTES + SPARE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             rd_req,
    output logic [ROW_W-1:0] rd_row,
    output logic [COL_W-1:0] rd_col,
    input  logic             rd_done,
    input  logic [7:0]       rd_byte,
    input  logic             rd_err,
    output logic             map_we,
    output logic [BLK_W-1:0] map_waddr,
    output logic             map_wbit,
    output logic             tally_clr,
    output logic             tally_bump,
    output logic             scan_busy,
    output logic             scan_done
);

    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);
    localparam logic [COL_W-1:0] MARK_COL = COL_W'(PAGE_DATA_BYTES);

    scan_state_t      state_q;
    logic [BLK_W-1:0] blk_q;
    logic [BLK_W-1:0] sweep_q;
    logic             taken;
    logic             bad_now;

    // Handshake: a read completes when done arrives during a request.
    always_comb begin
        taken   = rd_req && rd_done;
        bad_now = marker_is_bad(rd_byte, rd_err);
    end

    // Read-port outputs come straight from the state and the block index.
    always_comb begin
        rd_req = (state_q == ST_PAGE0) || (state_q == ST_PAGE1);
        rd_row = {blk_q, (state_q == ST_PAGE1) ? PG_W'(1) : PG_W'(0)};
        rd_col = MARK_COL;
    end

    // Map writes: zero sweep during the clear phase, a set bit for an invalid block.
    always_comb begin
        map_we    = 1'b0;
        map_waddr = blk_q;
        map_wbit  = 1'b0;
        if (!start) begin
            if (state_q == ST_CLEAR) begin
                map_we    = 1'b1;
                map_waddr = sweep_q;
            end else if (taken && bad_now) begin
                map_we   = 1'b1;
                map_wbit = 1'b1;
            end
        end
    end

    // Counter control and scan status flags.
    always_comb begin
        tally_clr  = start;
        tally_bump = !start && taken && bad_now;
        scan_busy  = (state_q != ST_IDLE) && (state_q != ST_DONE);
        scan_done  = (state_q == ST_DONE);
    end

    // Phase sequencing and the block and sweep indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            blk_q   <= '0;
            sweep_q <= '0;
        end else if (start) begin
            state_q <= ST_CLEAR;
            blk_q   <= '0;
            sweep_q <= '0;
        end else begin
            case (state_q)
                ST_CLEAR: begin
                    if (sweep_q == LAST_BLK) begin
                        state_q <= ST_PAGE0;
                    end else begin
                        sweep_q <= sweep_q + 1'b1;
                    end
                end
                ST_PAGE0: begin
                    if (taken) begin
                        state_q <= bad_now ? ST_ADVANCE : ST_PAGE1;
                    end
                end
                ST_PAGE1: begin
                    if (taken) begin
                        state_q <= ST_ADVANCE;
                    end
                end
                ST_ADVANCE: begin
                    if (blk_q == LAST_BLK) begin
                        state_q <= ST_DONE;
                    end else begin
                        blk_q   <= blk_q + 1'b1;
                        state_q <= ST_PAGE0;
                    end
                end
                default: state_q <= state_q;
            endcase
        end
    end

endmodule

// File: rtl/bad_block_scanner.sv
// Top level of the invalid block map builder.
// Joins the scan sequencer, the map RAM and the counter.
// Assumes: the read port answers every request eventually.
// Assumes: lookups are meaningful once scan_done is high.
module bad_block_scanner #(
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int PAGE_DATA_BYTES = 2048,
    parameter int SPARE_BYTES     = 64,
    parameter int MAX_BAD         = 40,
    localparam int BLK_W = $clog2(NUM_BLOCKS),
    localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
    localparam int ROW_W = BLK_W + PG_W,
    localparam int COL_W = $clog2(PAGE_DATA_BYTES + SPARE_BYTES),
    localparam int CNT_W = BLK_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             rd_req,
    output logic [ROW_W-1:0] rd_row,
    output logic [COL_W-1:0] rd_col,
    input  logic             rd_done,
    input  logic [7:0]       rd_byte,
    input  logic             rd_err,
    input  logic [BLK_W-1:0] lkp_blk,
    output logic             lkp_bad,
    output logic             scan_busy,
    output logic             scan_done,
    output logic [CNT_W-1:0] bad_count,
    output logic             too_many_bad
);

    logic             map_we;
    logic [BLK_W-1:0] map_waddr;
    logic             map_wbit;
    logic             tally_clr;
    logic             tally_bump;

    bbs_seq #(
        .NUM_BLOCKS     (NUM_BLOCKS),
        .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
        .PAGE_DATA_BYTES(PAGE_DATA_BYTES),
        .SPARE_BYTES    (SPARE_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rd_req    (rd_req),
        .rd_row    (rd_row),
        .rd_col    (rd_col),
        .rd_done   (rd_done),
        .rd_byte   (rd_byte),
        .rd_err    (rd_err),
        .map_we    (map_we),
        .map_waddr (map_waddr),
        .map_wbit  (map_wbit),
        .tally_clr (tally_clr),
        .tally_bump(tally_bump),
        .scan_busy (scan_busy),
        .scan_done (scan_done)
    );

    bbs_bitmap #(
        .DEPTH(NUM_BLOCKS)
    ) u_map (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (map_we),
        .waddr(map_waddr),
        .wbit (map_wbit),
        .raddr(lkp_blk),
        .rbit (lkp_bad)
    );

    bbs_tally #(
        .CNT_W  (CNT_W),
        .MAX_BAD(MAX_BAD)
    ) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tally_clr),
        .bump      (tally_bump),
        .count     (bad_count),
        .over_limit(too_many_bad)
    );

endmodule

// File: rtl/bbs_checks.sv
// Protocol and counter properties for bad_block_scanner.
// The module is attached to the top level by the bind statement at the end of this file.
module bbs_checks #(
    parameter int NUM_BLOCKS      = 2048,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int MAX_BAD         = 40,
    localparam int BLK_W = $clog2(NUM_BLOCKS),
    localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
    localparam int ROW_W = BLK_W + PG_W,
    localparam int CNT_W = BLK_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             rd_req,
    input logic             rd_done,
    input logic [ROW_W-1:0] rd_row,
    input logic [CNT_W-1:0] bad_count,
    input logic             too_many_bad,
    input logic             scan_done
);

    // R3: an unacknowledged request is held with the same row.
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_done && !start) |=> (rd_req && $stable(rd_row)));

    // R4: a page-1 request directly follows the page-0 request of the same block.
    a_r4_page1_follows_page0: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_row[PG_W-1:0] == PG_W'(1) && !$past(rd_req && rd_row[PG_W-1:0] == PG_W'(1)))
        |-> ($past(rd_req) && $past(rd_row) == {rd_row[ROW_W-1:PG_W], {PG_W{1'b0}}}));

    // R7: without an acknowledge or a start, the count holds.
    a_r7_count_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !(rd_req && rd_done)) |=> $stable(bad_count));

    // R7: within a scan the count moves by at most one per cycle.
    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (bad_count == $past(bad_count) || bad_count == $past(bad_count) + 1'b1));

    // R8: the flag rises exactly when the count first passes the limit.
    a_r8_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(too_many_bad) |-> (bad_count == CNT_W'(MAX_BAD + 1)));

    // R1: start clears the count, the flag and the done indication.
    a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (bad_count == '0 && !too_many_bad && !scan_done));

    // R9: no request is made once the scan has finished.
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> !rd_req);

endmodule

bind bad_block_scanner bbs_checks #(
    .NUM_BLOCKS     (NUM_BLOCKS),
    .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
    .MAX_BAD        (MAX_BAD)
) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .rd_req      (rd_req),
    .rd_done     (rd_done),
    .rd_row      (rd_row),
    .bad_count   (bad_count),
    .too_many_bad(too_many_bad),
    .scan_done   (scan_done)
);

// File: tb/tb_bad_block_scanner.sv
// Bench for bad_block_scanner.
// A behavioural read-port responder and reference model are compared on every falling edge.
module tb_bad_block_scanner;

    localparam int NB    = 64;
    localparam int PPB   = 64;
    localparam int DATA  = 2048;
    localparam int SPARE = 64;
    localparam int MAXB  = 4;
    localparam int LAT   = 2;
    localparam int BLK_W = $clog2(NB);
    localparam int ROW_W = BLK_W + $clog2(PPB);
    localparam int COL_W = $clog2(DATA + SPARE);
    localparam int CNT_W = BLK_W + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             rd_req;
    logic [ROW_W-1:0] rd_row;
    logic [COL_W-1:0] rd_col;
    logic             rd_done = 1'b0;
    logic [7:0]       rd_byte = 8'hFF;
    logic             rd_err = 1'b0;
    logic [BLK_W-1:0] lkp_blk = '0;
    logic             lkp_bad;
    logic             scan_busy;
    logic             scan_done;
    logic [CNT_W-1:0] bad_count;
    logic             too_many_bad;

    int nchk  = 0;
    int nfail = 0;
    bit reported = 0;
    bit m_map [NB];
    int m_count = 0;

    always #4 clk = ~clk;

    bad_block_scanner #(
        .NUM_BLOCKS     (NB),
        .PAGES_PER_BLOCK(PPB),
        .PAGE_DATA_BYTES(DATA),
        .SPARE_BYTES    (SPARE),
        .MAX_BAD        (MAXB)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .rd_req      (rd_req),
        .rd_row      (rd_row),
        .rd_col      (rd_col),
        .rd_done     (rd_done),
        .rd_byte     (rd_byte),
        .rd_err      (rd_err),
        .lkp_blk     (lkp_blk),
        .lkp_bad     (lkp_bad),
        .scan_busy   (scan_busy),
        .scan_done   (scan_done),
        .bad_count   (bad_count),
        .too_many_bad(too_many_bad)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("test done: total=%0d bad=%0d", nchk, nfail);
            $finish;
        end
    endtask

    // Marker pattern per scan: returns {err, byte}.
    function automatic logic [8:0] answer(input int s, input int b, input int p);
        logic [8:0] r = {1'b0, 8'hFF};
        if (s == 0) begin
            if (b == 1 && p == 0) r = {1'b0, 8'h00};
            if (b == 5 && p == 1) r = {1'b0, 8'hFE};
            if (b == 10 && p == 0) r = {1'b1, 8'hFF};
            if (b == NB - 1 && p == 1) r = {1'b1, 8'hFF};
        end else if (s == 1) begin
            if (b == 0 && p == 0) r = {1'b0, 8'h00};
            if (b >= 2 && b <= 4 && p == 1) r = {1'b0, 8'h80};
            if (b == NB - 2 && p == 0) r = {1'b1, 8'hFF};
            if (b == NB - 1 && p == 0) r = {1'b0, 8'hEF};
        end
        return r;
    endfunction

    // One full scan with responder and per-cycle comparison.
    task automatic run_scan(input int s);
        int e = 1;
        int wait_c = 0;
        bit drv = 0;
        bit fin = 0;
        int fin_e = 0;
        bit pend_bad = 0;
        int exp_blk = 0;
        int exp_pg = 0;
        int held_row = 0;
        logic [8:0] ans = '0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        m_count = 0;
        for (int i = 0; i < NB; i++) m_map[i] = 0;
        chk(scan_busy && !scan_done && bad_count == '0 && !too_many_bad,
            "R1 start state", int'(scan_busy), 1);
        forever begin
            if (e == NB) chk(!rd_req, "R2 no request during clear", int'(rd_req), 0);
            if (e == NB + 1) chk(rd_req, "R2 first request after clear", int'(rd_req), 1);
            if (drv) begin
                rd_done = 1'b0;
                drv = 0;
                if (pend_bad) begin
                    m_count++;
                    m_map[exp_blk] = 1;
                end
                if (pend_bad || exp_pg == 1) begin
                    if (exp_blk == NB - 1) begin
                        fin = 1;
                        fin_e = e;
                    end
                    exp_blk++;
                    exp_pg = 0;
                end else begin
                    exp_pg = 1;
                end
            end else if (wait_c > 0) begin
                chk(rd_req && int'(rd_row) == held_row, "R3 request held", int'(rd_row), held_row);
                wait_c--;
                if (wait_c == 0) begin
                    rd_done = 1'b1;
                    rd_err = ans[8];
                    rd_byte = ans[7:0];
                    drv = 1;
                end
            end else if (rd_req && !fin) begin
                held_row = exp_blk * PPB + exp_pg;
                chk(int'(rd_row) == held_row, "R3 R4 request row", int'(rd_row), held_row);
                chk(int'(rd_col) == DATA, "R3 marker column", int'(rd_col), DATA);
                ans = answer(s, exp_blk, exp_pg);
                pend_bad = ans[8] || (ans[7:0] != 8'hFF);
                wait_c = LAT;
            end
            if (fin) chk(!rd_req, "R9 no request after last block", int'(rd_req), 0);
            chk(int'(bad_count) == m_count, "R5 R7 bad count", int'(bad_count), m_count);
            chk(too_many_bad == (m_count > MAXB), "R8 limit flag", int'(too_many_bad), int'(m_count > MAXB));
            chk(scan_done == (fin && e > fin_e), "R9 done timing", int'(scan_done), int'(fin && e > fin_e));
            if (fin && e == fin_e + 2) break;
            @(negedge clk);
            e++;
        end
        chk(!scan_busy, "R9 not busy when done", int'(scan_busy), 0);
    endtask

    // Read back the whole map through the lookup port.
    task automatic verify_map(input string tag);
        for (int b = 0; b < NB; b++) begin
            lkp_blk = BLK_W'(b);
            @(negedge clk);
            chk(lkp_bad == m_map[b], tag, int'(lkp_bad), int'(m_map[b]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_req && !scan_busy && !scan_done && !too_many_bad && bad_count == '0,
            "R10 reset state", int'(bad_count), 0);
        run_scan(0);
        chk(m_count == MAXB && !too_many_bad, "R8 count equal to limit", int'(too_many_bad), 0);
        verify_map("R6 map after scan 0");
        repeat (3) @(negedge clk);
        chk(scan_done && !rd_req, "R9 done holds", int'(scan_done), 1);
        run_scan(1);
        chk(too_many_bad == 1'b1, "R8 over limit", int'(too_many_bad), 1);
        verify_map("R6 map after scan 1");
        run_scan(2);
        chk(bad_count == '0, "R5 all blank count", int'(bad_count), 0);
        verify_map("R2 map cleared by rescan");
        report();
    end

endmodule